// File: doc/BRIEF.md
# DMA Channel Address and Count Tracker with Chained Reload

This block keeps the moving state of a single DMA channel. It holds three working registers: a source address, a destination address and a 24-bit count of bytes still to move. Beside them sit a reload copy of each and an arm bit. Read beats into the FIFO and write beats out of it arrive as one-cycle strobes. On each read beat the block takes the beat size from the count and the programmed source width, and it advances the source address and reduces the count by that size. On each write beat it advances the destination address by the programmed destination width.

The last read beat brings the count to zero. If the arm bit is set at that point, the working registers are refilled from the reload copies, so a chained buffer starts without a gap, and the arm bit clears itself. If the arm bit is clear, the channel stops.

The controller has two states. In IDLE, read beats do nothing and a start strobe loads the working registers. In RUN, read beats are counted. There are three transitions. START goes from IDLE to RUN on a start strobe with a nonzero count. CHAIN goes from RUN to RUN on a count-to-zero with the arm bit set. FINISH goes from RUN to IDLE on a count-to-zero with the arm bit clear.

Top module: `dma_span_tracker`

## Requirements
- R1: After reset the channel is IDLE (`busy`=0). `src_addr`, `dst_addr`, `remain` and `armed` are 0, and no pulse output is high.
- R2: A `start` strobe in IDLE loads `src_addr`, `dst_addr` and `remain` from `ld_src`, `ld_dst` and `ld_cnt` at the next edge. It enters RUN only when `ld_cnt` is nonzero. A `start` strobe in RUN changes nothing.
- R3: Width codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and code 3 acts as 2. `rd_size` is the largest size that does not exceed the `src_width` code and is not larger than `remain` in bytes. It falls back to code 0 when `remain` is 0 or 1.
- R4: A read beat in RUN subtracts the beat size from `remain`, stopping at 0. The same beat adds the size to `src_addr` when source increment is in effect. A read beat in IDLE has no effect.
- R5: A write beat adds 1, 2 or 4 bytes (from `dst_width`) to `dst_addr` when destination increment is in effect, in either state. A `start` load or a reload in the same cycle takes precedence.
- R6: `xfer_kind` selects the transfer type. Code 1 (peripheral receive) holds the source address fixed. Code 2 (peripheral transmit) holds the destination address fixed. Codes 0 and 3 follow `src_inc`/`dst_inc`.
- R7: `ctz_pulse` is high in the same cycle as a RUN read beat whose size is at least the remaining count.
- R8: On a count-to-zero with `armed`=1, the next edge loads all three working registers from the reload copies, clears `armed` and stays in RUN. `reload_pulse` is high in the count-to-zero cycle.
- R9: On a count-to-zero with `armed`=0, the channel goes to IDLE at the next edge. `idle_pulse` is high in the count-to-zero cycle, and `src_addr` still takes that last beat's step.
- R10: `rld_wr` stores `rld_src`, `rld_dst` and `rld_cnt` and sets `armed` to `rld_arm`. In the same cycle as a reload, the write wins over the self-clear.
- R11: `reload_pulse` and `idle_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the working registers and start the channel |
| ld_src | input | ADDR_W | Source address to load |
| ld_dst | input | ADDR_W | Destination address to load |
| ld_cnt | input | CNT_W | Byte count to load |
| rld_wr | input | 1 | Write the reload copies and the arm bit |
| rld_src | input | ADDR_W | Source reload value |
| rld_dst | input | ADDR_W | Destination reload value |
| rld_cnt | input | CNT_W | Count reload value |
| rld_arm | input | 1 | Arm bit value written with `rld_wr` |
| src_width | input | 2 | Programmed source width code |
| src_inc | input | 1 | Source increment request |
| dst_width | input | 2 | Destination width code |
| dst_inc | input | 1 | Destination increment request |
| xfer_kind | input | 2 | Transfer type: 0 memory, 1 peripheral receive, 2 peripheral transmit, 3 memory |
| rd_beat | input | 1 | One read beat into the FIFO |
| wr_beat | input | 1 | One write beat out of the FIFO |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| remain | output | CNT_W | Bytes still to read |
| rd_size | output | 2 | Size code for the current read beat |
| busy | output | 1 | Channel is in RUN |
| armed | output | 1 | Reload is armed |
| ctz_pulse | output | 1 | Count-to-zero in this cycle |
| reload_pulse | output | 1 | Chained reload in this cycle |
| idle_pulse | output | 1 | Active-to-idle event in this cycle |

## Verification
`rd_size`, `ctz_pulse`, `reload_pulse` and `idle_pulse` are combinational from the current state and the strobes, so they are valid in the cycle the beat is presented. The addresses, `remain`, `busy` and `armed` pass through one register and show a beat's effect after the next rising edge. The bench drives inputs on the falling edge and checks the combinational outputs 1 ns later. It then checks the registered outputs at the following falling edge against a behavioural model that updated on the rising edge in between. Every cycle is compared in this way, including the cycle where a chain or finish coincides with a write beat or a reload write.

// File: rtl/span_pkg.sv
package span_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [1:0] KIND_PER_RX = 2'd1;
    localparam logic [1:0] KIND_PER_TX = 2'd2;

    // code 3 is treated as a full word
    function automatic logic [1:0] clamp_width(input logic [1:0] code);
        return (code > SZ_WORD) ? SZ_WORD : code;
    endfunction

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        return 3'd1 << clamp_width(code);
    endfunction

endpackage

// File: rtl/span_beat_sizer.sv
module span_beat_sizer
    import span_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [CNT_W-1:0] remain,
    input  logic [1:0]       width_code,
    output logic [1:0]       size_code,
    output logic [2:0]       size_bytes
);

    logic [1:0] w_eff;

    always_comb begin
        w_eff = clamp_width(width_code);
        if (w_eff == SZ_WORD && remain >= CNT_W'(4)) begin
            size_code = SZ_WORD;
        end else if (w_eff != SZ_BYTE && remain >= CNT_W'(2)) begin
            size_code = SZ_HALF;
        end else begin
            size_code = SZ_BYTE;
        end
        size_bytes = 3'd1 << size_code;
    end

endmodule

// File: rtl/span_addr_track.sv
module span_addr_track #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              rld_en,
    input  logic [ADDR_W-1:0] rld_val,
    input  logic              step_en,
    input  logic [2:0]        step,
    output logic [ADDR_W-1:0] addr
);

    // priority: software load, then chained reload, then step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_en) begin
            addr <= load_val;
        end else if (rld_en) begin
            addr <= rld_val;
        end else if (step_en) begin
            addr <= addr + ADDR_W'(step);
        end
    end

endmodule

// File: rtl/span_count.sv
module span_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             rld_en,
    input  logic [CNT_W-1:0] rld_val,
    input  logic             dec_en,
    input  logic [2:0]       step,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_hit
);

    logic last_beat;

    always_comb begin
        last_beat = cnt <= CNT_W'(step);
        zero_hit  = dec_en && last_beat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (rld_en) begin
            cnt <= rld_val;
        end else if (dec_en) begin
            cnt <= last_beat ? '0 : cnt - CNT_W'(step);
        end
    end

endmodule

// File: rtl/dma_span_tracker.sv
module dma_span_tracker
    import span_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              rld_wr,
    input  logic [ADDR_W-1:0] rld_src,
    input  logic [ADDR_W-1:0] rld_dst,
    input  logic [CNT_W-1:0]  rld_cnt,
    input  logic              rld_arm,
    input  logic [1:0]        src_width,
    input  logic              src_inc,
    input  logic [1:0]        dst_width,
    input  logic              dst_inc,
    input  logic [1:0]        xfer_kind,
    input  logic              rd_beat,
    input  logic              wr_beat,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  remain,
    output logic [1:0]        rd_size,
    output logic              busy,
    output logic              armed,
    output logic              ctz_pulse,
    output logic              reload_pulse,
    output logic              idle_pulse
);

    localparam int N_TRK   = 2;
    localparam int TRK_SRC = 0;
    localparam int TRK_DST = 1;

    run_state_e state_q, state_nx;

    logic              armed_q;
    logic [ADDR_W-1:0] rsrc_q, rdst_q;
    logic [CNT_W-1:0]  rcnt_q;

    logic       start_ok, beat_ok, zero_hit, chain;
    logic [2:0] rd_bytes;

    logic [ADDR_W-1:0] trk_load [N_TRK];
    logic [ADDR_W-1:0] trk_rld  [N_TRK];
    logic [ADDR_W-1:0] trk_q    [N_TRK];
    logic              trk_step_en [N_TRK];
    logic [2:0]        trk_step [N_TRK];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && ld_cnt != '0) begin
                    state_nx = ST_RUN;          // START
                end
            end
            ST_RUN: begin
                if (zero_hit && !armed_q) begin
                    state_nx = ST_IDLE;         // FINISH
                end                             // CHAIN stays in RUN
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs and control ----------------
    always_comb begin
        busy         = (state_q == ST_RUN);
        start_ok     = start && (state_q == ST_IDLE);
        beat_ok      = rd_beat && (state_q == ST_RUN);
        chain        = zero_hit && armed_q;
        ctz_pulse    = zero_hit;
        reload_pulse = chain;
        idle_pulse   = zero_hit && !armed_q;
        armed        = armed_q;
    end

    // ---------------- reload copies and arm bit ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsrc_q  <= '0;
            rdst_q  <= '0;
            rcnt_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (rld_wr) begin
                rsrc_q  <= rld_src;
                rdst_q  <= rld_dst;
                rcnt_q  <= rld_cnt;
                armed_q <= rld_arm;
            end else if (chain) begin
                armed_q <= 1'b0;
            end
        end
    end

    // ---------------- beat sizing ----------------
    span_beat_sizer #(.CNT_W(CNT_W)) u_sizer (
        .remain     (remain),
        .width_code (src_width),
        .size_code  (rd_size),
        .size_bytes (rd_bytes)
    );

    // ---------------- count ----------------
    span_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (start_ok),
        .load_val (ld_cnt),
        .rld_en   (chain),
        .rld_val  (rcnt_q),
        .dec_en   (beat_ok),
        .step     (rd_bytes),
        .cnt      (remain),
        .zero_hit (zero_hit)
    );

    // ---------------- address trackers ----------------
    always_comb begin
        trk_load[TRK_SRC]    = ld_src;
        trk_rld[TRK_SRC]     = rsrc_q;
        trk_step_en[TRK_SRC] = beat_ok && src_inc && (xfer_kind != KIND_PER_RX);
        trk_step[TRK_SRC]    = rd_bytes;
        trk_load[TRK_DST]    = ld_dst;
        trk_rld[TRK_DST]     = rdst_q;
        trk_step_en[TRK_DST] = wr_beat && dst_inc && (xfer_kind != KIND_PER_TX);
        trk_step[TRK_DST]    = width_bytes(dst_width);
    end

    for (genvar g = 0; g < N_TRK; g++) begin : g_trk
        span_addr_track #(.ADDR_W(ADDR_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (start_ok),
            .load_val (trk_load[g]),
            .rld_en   (chain),
            .rld_val  (trk_rld[g]),
            .step_en  (trk_step_en[g]),
            .step     (trk_step[g]),
            .addr     (trk_q[g])
        );
    end

    assign src_addr = trk_q[TRK_SRC];
    assign dst_addr = trk_q[TRK_DST];

endmodule

// File: rtl/span_checks.sv
module span_checks #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rld_wr,
    input logic [1:0]        xfer_kind,
    input logic              rd_beat,
    input logic [ADDR_W-1:0] src_addr,
    input logic [CNT_W-1:0]  remain,
    input logic [1:0]        rd_size,
    input logic              busy,
    input logic              armed,
    input logic              ctz_pulse,
    input logic              reload_pulse,
    input logic              idle_pulse
);

    // R3: a beat never claims more bytes than remain
    assert_size_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain != '0) |-> (remain >= CNT_W'(3'd1 << rd_size)));

    // R4: count only falls while running, except through a reload
    assert_count_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reload_pulse) |=> (remain <= $past(remain)));

    // R6: peripheral receive keeps the source address fixed
    assert_rx_src_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_beat && xfer_kind == 2'd1 && !reload_pulse) |=> $stable(src_addr));

    // R7: count-to-zero only on a running read beat
    assert_ctz_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctz_pulse |-> (rd_beat && busy));

    // R8: arm bit self-clears after a chain
    assert_arm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_pulse && !rld_wr) |=> !armed);

    // R8: a chain keeps the channel running
    assert_chain_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |=> busy);

    // R9: finishing leaves the channel idle
    assert_finish_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !busy);

    // R11: chain and finish are exclusive
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reload_pulse, idle_pulse}));

endmodule

bind dma_span_tracker span_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .rld_wr       (rld_wr),
    .xfer_kind    (xfer_kind),
    .rd_beat      (rd_beat),
    .src_addr     (src_addr),
    .remain       (remain),
    .rd_size      (rd_size),
    .busy         (busy),
    .armed        (armed),
    .ctz_pulse    (ctz_pulse),
    .reload_pulse (reload_pulse),
    .idle_pulse   (idle_pulse)
);

// File: tb/sim_dma_span_tracker.sv
module sim_dma_span_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ld_src = '0, ld_dst = '0;
    logic [23:0] ld_cnt = '0;
    logic        rld_wr = 1'b0;
    logic [31:0] rld_src = '0, rld_dst = '0;
    logic [23:0] rld_cnt = '0;
    logic        rld_arm = 1'b0;
    logic [1:0]  src_width = '0, dst_width = '0, xfer_kind = '0;
    logic        src_inc = 1'b0, dst_inc = 1'b0;
    logic        rd_beat = 1'b0, wr_beat = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic [23:0] remain;
    logic [1:0]  rd_size;
    logic        busy, armed, ctz_pulse, reload_pulse, idle_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    dma_span_tracker u0 (.*);

    always #4 clk = ~clk;   // 125 MHz

    // ---------------- reference model ----------------
    logic [31:0] m_src = '0, m_dst = '0, m_rsrc = '0, m_rdst = '0;
    logic [23:0] m_cnt = '0, m_rcnt = '0;
    bit          m_busy = 1'b0, m_armed = 1'b0;

    function automatic int beat_bytes(input logic [1:0] w, input logic [23:0] c);
        int ww = (w == 2'd3) ? 2 : int'(w);
        if (ww == 2 && c >= 4) return 4;
        if (ww >= 1 && c >= 2) return 2;
        return 1;
    endfunction

    function automatic int code_of(input int b);
        return (b == 4) ? 2 : (b == 2) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = '0; m_dst = '0; m_cnt = '0;
            m_rsrc = '0; m_rdst = '0; m_rcnt = '0;
            m_busy = 0; m_armed = 0;
        end else begin
            int   b, db;
            bit   beat, hit, chn;
            b    = beat_bytes(src_width, m_cnt);
            db   = 1 << ((dst_width == 2'd3) ? 2 : int'(dst_width));
            beat = rd_beat && m_busy;
            hit  = beat && (m_cnt <= b);
            chn  = hit && m_armed;
            if (start && !m_busy) begin
                m_src = ld_src; m_dst = ld_dst; m_cnt = ld_cnt;
                m_busy = (ld_cnt != 0);
            end else begin
                if (wr_beat && dst_inc && xfer_kind != 2'd2) m_dst = m_dst + db;
                if (beat) begin
                    m_cnt = hit ? 24'd0 : m_cnt - b;
                    if (src_inc && xfer_kind != 2'd1) m_src = m_src + b;
                end
                if (chn) begin
                    m_src = m_rsrc; m_dst = m_rdst; m_cnt = m_rcnt;
                end else if (hit) begin
                    m_busy = 0;
                end
            end
            if (rld_wr) begin
                m_rsrc = rld_src; m_rdst = rld_dst; m_rcnt = rld_cnt; m_armed = rld_arm;
            end else if (chn) begin
                m_armed = 0;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_comb();
        int b  = beat_bytes(src_width, m_cnt);
        bit hit = rd_beat && m_busy && (m_cnt <= b);
        chk(rd_size == 2'(code_of(b)), "R3 rd_size", rd_size, code_of(b));
        chk(ctz_pulse == hit, "R7 ctz_pulse", ctz_pulse, hit);
        chk(reload_pulse == (hit && m_armed), "R8 reload_pulse", reload_pulse, hit && m_armed);
        chk(idle_pulse == (hit && !m_armed), "R9 idle_pulse", idle_pulse, hit && !m_armed);
        chk(!(reload_pulse && idle_pulse), "R11 exclusive", {reload_pulse, idle_pulse}, 0);
    endtask

    task automatic cmp_regs();
        chk(src_addr == m_src, "R4 src_addr", src_addr, m_src);
        chk(dst_addr == m_dst, "R5 dst_addr", dst_addr, m_dst);
        chk(remain == m_cnt, "R4 remain", remain, m_cnt);
        chk(busy == m_busy, "R2 busy", busy, m_busy);
        chk(armed == m_armed, "R10 armed", armed, m_armed);
    endtask

    // called just after a falling edge with inputs already set
    task automatic cyc();
        #1;
        cmp_comb();
        @(negedge clk);
        cmp_regs();
        start = 0; rd_beat = 0; wr_beat = 0; rld_wr = 0;
    endtask

    task automatic cfg(input logic [1:0] sw, input bit si, input logic [1:0] dw,
                       input bit di, input logic [1:0] kind);
        src_width = sw; src_inc = si; dst_width = dw; dst_inc = di; xfer_kind = kind;
    endtask

    task automatic go(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c);
        ld_src = s; ld_dst = d; ld_cnt = c; start = 1; cyc();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk(busy == 0 && armed == 0, "R1 busy/armed", {busy, armed}, 0);
        chk(src_addr == 0 && dst_addr == 0 && remain == 0, "R1 regs", remain, 0);
        chk(!ctz_pulse && !reload_pulse && !idle_pulse, "R1 pulses",
            {ctz_pulse, reload_pulse, idle_pulse}, 0);
        @(negedge clk);

        // memory to memory, count 10, word width: 4,4,2
        cfg(2'd2, 1, 2'd2, 1, 2'd0);
        go(32'h1000, 32'h2000, 24'd10);
        rd_beat = 1; wr_beat = 1; cyc();
        rd_beat = 1; cyc();
        rd_beat = 1; wr_beat = 1; cyc();
        chk(remain == 0 && busy == 0, "R9 finish", {remain, busy}, 0);
        chk(src_addr == 32'h100A, "R4 src end", src_addr, 32'h100A);
        rd_beat = 1; cyc();                          // R4: ignored in IDLE
        chk(remain == 0 && src_addr == 32'h100A, "R4 idle beat ignored", src_addr, 32'h100A);
        wr_beat = 1; cyc();                          // R5: drain in IDLE
        chk(dst_addr == 32'h200C, "R5 idle write", dst_addr, 32'h200C);

        // peripheral receive, count 7: 4,2,1, source fixed
        cfg(2'd2, 1, 2'd0, 1, 2'd1);
        go(32'h3000, 32'h4000, 24'd7);
        repeat (3) begin rd_beat = 1; wr_beat = 1; cyc(); end
        chk(src_addr == 32'h3000, "R6 rx src fixed", src_addr, 32'h3000);
        chk(dst_addr == 32'h4003, "R6 rx dst steps", dst_addr, 32'h4003);

        // peripheral transmit, halfword, count 5: 2,2,1, destination fixed
        cfg(2'd1, 1, 2'd2, 1, 2'd2);
        go(32'h5000, 32'h6000, 24'd5);
        start = 1; ld_cnt = 24'd99; rd_beat = 1; cyc();   // R2: start while busy ignored
        chk(remain == 24'd3, "R2 start ignored", remain, 3);
        repeat (2) begin rd_beat = 1; wr_beat = 1; cyc(); end
        chk(dst_addr == 32'h6000, "R6 tx dst fixed", dst_addr, 32'h6000);

        // zero-count start stays idle
        go(32'h7000, 32'h7100, 24'd0);
        chk(busy == 0, "R2 zero count", busy, 0);

        // chaining: arm, byte beats on 2, then reload 4 and finish
        ld_cnt = 0;
        rld_src = 32'h8000; rld_dst = 32'h9000; rld_cnt = 24'd4; rld_arm = 1; rld_wr = 1; cyc();
        cfg(2'd0, 1, 2'd0, 1, 2'd0);
        go(32'hA000, 32'hB000, 24'd2);
        rd_beat = 1; cyc();
        rd_beat = 1; wr_beat = 1; cyc();
        chk(src_addr == 32'h8000 && dst_addr == 32'h9000 && remain == 4,
            "R8 reloaded", remain, 4);
        chk(armed == 0 && busy == 1, "R8 arm cleared", {armed, busy}, 1);
        src_width = 2'd3; rd_beat = 1; cyc();         // R3: code 3 acts as word
        chk(busy == 0 && src_addr == 32'h8004, "R9 end after chain", src_addr, 32'h8004);

        // reload write in the chain cycle keeps arm (R10)
        rld_arm = 1; rld_wr = 1; rld_cnt = 24'd3; cyc();
        cfg(2'd2, 1, 2'd1, 1, 2'd3);
        go(32'hC000, 32'hD000, 24'd3);
        rd_beat = 1; cyc();
        rld_wr = 1; rld_arm = 1; rd_beat = 1; cyc();
        chk(armed == 1, "R10 write beats self-clear", armed, 1);

        // mixed pattern
        for (int i = 0; i < 120; i++) begin
            start     = (i % 9 == 0);
            ld_src    = 32'h100 * i;
            ld_dst    = 32'hFFFF_FFF0 + i;
            ld_cnt    = 24'(i % 11);
            rld_wr    = (i % 13 == 5);
            rld_arm   = i[0];
            rld_src   = 32'h4400 + i;
            rld_dst   = 32'h5500 + i;
            rld_cnt   = 24'(i % 7);
            src_width = 2'(i % 4);
            dst_width = 2'((i + 1) % 4);
            xfer_kind = 2'(i / 7 % 4);
            src_inc   = (i % 5 != 0);
            dst_inc   = 1;
            rd_beat   = (i % 3 != 2);
            wr_beat   = (i % 2 == 0);
            cyc();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule